// File: doc/BRIEF.md
# Register Access Call Wrapper

This block turns a register access on an external bus transceiver into a single call. The caller gives a register address, a read/write select and, for writes, a data byte, and pulses a start strobe. The wrapper latches the request and drives address, select and write data toward the transceiver. It raises the transceiver's go strobe only after those lines have settled. When the transceiver reports completion, the wrapper captures the returned byte and hands the caller a done pulse delayed so that the byte is already stable.

Every deliberate delay is a chain of flip-flops alternating between the rising and the falling clock edge. Each flop shifts the signal by half a cycle. So go and done change on falling edges, while address, select and data change on rising edges, and the two never move together. The returned byte is also captured on a falling edge, midway through the transceiver's done strobe.

A parameter selects a fixed-address variant. It always targets register 0x01, the auto-read receive data register, which is used to stream packet bytes. In that variant the caller's address is not used; every other signal behaves exactly as in the general form.

The controller has five named states. IDLE waits for start. ISSUE lasts one cycle and launches the go request. WAIT holds until the transceiver's done is sampled. NOTIFY lasts one cycle and launches the done pulse. SETTLE lasts one cycle and covers the delayed pulse. The transitions are: IDLE to ISSUE on an accepted start, ISSUE to WAIT always, WAIT to NOTIFY on transceiver done, NOTIFY to SETTLE always, and SETTLE to IDLE always.

Top module: `acc_call_wrapper`

## Requirements
- R1: While a request is in progress, `xcvr_rw_o` is 1 for a read and 0 for a write. `xcvr_wdata_o` carries the caller's byte for a write and is 0 for a read.
- R2: Address, select and write data are latched on the rising edge that accepts start. They stay unchanged until the request completes.
- R3: With the default go delay of one cycle, `xcvr_go_o` is high for exactly one clock, from the falling edge after the first rising edge following acceptance to the next falling edge. It is therefore sampled high only at the second rising edge after the accepting edge.
- R4: `done_o` is a one-clock pulse between falling edges. It is sampled high at the second rising edge after the rising edge at which `xcvr_done_i` was first sampled high in WAIT.
- R5: For a read, `rdata_o` takes `xcvr_rdata_i` on the falling edge while `xcvr_done_i` is high in WAIT. It keeps that value through later writes until the next completed read.
- R6: `busy_o` rises on the accepting edge and falls on the rising edge inside the done pulse. A start seen while busy is ignored: no second go, and the latched lines do not change.
- R7: With the fixed-address variant selected, `xcvr_addr_o` is 0x01 for every request whatever `addr_i` is. Select, data, timing and returned byte match the general form.
- R8: After reset, `busy_o`, `done_o` and `xcvr_go_o` are 0, and `rdata_o` and `xcvr_addr_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both edges are used |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request strobe |
| rw_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | ADDR_W | Register address (unused in fixed variant) |
| wdata_i | input | DATA_W | Byte to write |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | Delayed completion pulse |
| rdata_o | output | DATA_W | Last byte read |
| xcvr_addr_o | output | ADDR_W | Address toward transceiver |
| xcvr_rw_o | output | 1 | Read/write select toward transceiver |
| xcvr_wdata_o | output | DATA_W | Write data toward transceiver |
| xcvr_go_o | output | 1 | Delayed go strobe |
| xcvr_done_i | input | 1 | Transceiver completion strobe |
| xcvr_rdata_i | input | DATA_W | Byte returned by transceiver |

## Verification
The assertions watch, on every rising edge, the rules that hold at any moment. Address and select stay steady while busy, and read requests carry zero write data. Go and done are single-cycle pulses that only occur while busy, and an accepted start always raises busy. Only the bench's transactions can show the exact edge counts: go two edges after acceptance, and done two edges after the transceiver's completion. The bench also shows that the byte returned is the one the modelled transceiver offered, that the byte survives writes, that a start issued mid-transfer leaves no trace, and that the fixed variant substitutes address 0x01.

// File: rtl/acc_pkg.sv
package acc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ISSUE  = 3'd1,
        ST_WAIT   = 3'd2,
        ST_NOTIFY = 3'd3,
        ST_SETTLE = 3'd4
    } acc_state_e;

endpackage

// File: rtl/acc_halfstep_delay.sv
// Delay of CYCLES clocks built from alternating rising/falling stages,
// each shifting the signal by half a cycle.
module acc_halfstep_delay #(
    parameter int W      = 1,
    parameter int CYCLES = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] rise_q [CYCLES];
    logic [W-1:0] fall_q [CYCLES];

    for (genvar i = 0; i < CYCLES; i++) begin : g_stage
        logic [W-1:0] stage_in;
        if (i == 0) begin : g_first
            assign stage_in = d;
        end else begin : g_next
            assign stage_in = fall_q[i-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rise_q[i] <= '0;
            else        rise_q[i] <= stage_in;
        end

        always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) fall_q[i] <= '0;
            else        fall_q[i] <= rise_q[i];
        end
    end

    assign q = fall_q[CYCLES-1];
endmodule

// File: rtl/acc_seq_fsm.sv
module acc_seq_fsm
    import acc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic xcvr_done_i,
    input  logic rd_req_i,
    output logic accept_o,
    output logic go_raw_o,
    output logic capture_en_o,
    output logic done_raw_o,
    output logic busy_o
);
    acc_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_ISSUE;
            ST_ISSUE:  state_d = ST_WAIT;
            ST_WAIT:   if (xcvr_done_i) state_d = ST_NOTIFY;
            ST_NOTIFY: state_d = ST_SETTLE;
            ST_SETTLE: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        accept_o     = 1'b0;
        go_raw_o     = 1'b0;
        capture_en_o = 1'b0;
        done_raw_o   = 1'b0;
        busy_o       = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy_o   = 1'b0;
                accept_o = start_i;
            end
            ST_ISSUE:  go_raw_o     = 1'b1;
            ST_WAIT:   capture_en_o = rd_req_i;
            ST_NOTIFY: done_raw_o   = 1'b1;
            ST_SETTLE: busy_o       = 1'b1;
            default:   busy_o       = 1'b0;
        endcase
    end
endmodule

// File: rtl/acc_rd_capture.sv
// Captures the returned byte on the falling edge, mid-strobe.
module acc_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_en_i,
    input  logic              xcvr_done_i,
    input  logic [DATA_W-1:0] xcvr_rdata_i,
    output logic [DATA_W-1:0] rdata_o
);
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n)                           rdata_o <= '0;
        else if (capture_en_i && xcvr_done_i) rdata_o <= xcvr_rdata_i;
    end
endmodule

// File: rtl/acc_call_wrapper.sv
module acc_call_wrapper #(
    parameter int          ADDR_W     = 8,
    parameter int          DATA_W     = 8,
    parameter int          GO_DELAY   = 1,
    parameter int          DONE_DELAY = 1,
    parameter bit          USE_FIXED  = 1'b0,
    parameter int unsigned FIXED_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              rw_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic [ADDR_W-1:0] xcvr_addr_o,
    output logic              xcvr_rw_o,
    output logic [DATA_W-1:0] xcvr_wdata_o,
    output logic              xcvr_go_o,
    input  logic              xcvr_done_i,
    input  logic [DATA_W-1:0] xcvr_rdata_i
);
    localparam logic [ADDR_W-1:0] FIX_A = ADDR_W'(FIXED_ADDR);

    logic              accept, go_raw, capture_en, done_raw;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              rw_q;

    acc_seq_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .xcvr_done_i  (xcvr_done_i),
        .rd_req_i     (rw_q),
        .accept_o     (accept),
        .go_raw_o     (go_raw),
        .capture_en_o (capture_en),
        .done_raw_o   (done_raw),
        .busy_o       (busy_o)
    );

    // Request parameters, latched once per accepted start.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            rw_q    <= 1'b0;
            wdata_q <= '0;
        end else if (accept) begin
            rw_q    <= rw_i;
            wdata_q <= rw_i ? '0 : wdata_i;
            if (USE_FIXED) addr_q <= FIX_A;
            else           addr_q <= addr_i;
        end
    end

    if (USE_FIXED) begin : g_fixed
        assign xcvr_addr_o = busy_o ? FIX_A : addr_q;
    end else begin : g_free
        assign xcvr_addr_o = addr_q;
    end

    assign xcvr_rw_o    = rw_q;
    assign xcvr_wdata_o = wdata_q;

    acc_halfstep_delay #(.W(1), .CYCLES(GO_DELAY)) u_go_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (go_raw),
        .q     (xcvr_go_o)
    );

    acc_halfstep_delay #(.W(1), .CYCLES(DONE_DELAY)) u_done_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (done_raw),
        .q     (done_o)
    );

    acc_rd_capture #(.DATA_W(DATA_W)) u_cap (
        .clk          (clk),
        .rst_n        (rst_n),
        .capture_en_i (capture_en),
        .xcvr_done_i  (xcvr_done_i),
        .xcvr_rdata_i (xcvr_rdata_i),
        .rdata_o      (rdata_o)
    );
endmodule

// File: rtl/acc_call_checker.sv
module acc_call_checker #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              xcvr_go_o,
    input logic              xcvr_rw_o,
    input logic [ADDR_W-1:0] xcvr_addr_o,
    input logic [DATA_W-1:0] xcvr_wdata_o
);
    assert_busy_on_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(xcvr_addr_o));

    assert_rw_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(xcvr_rw_o));

    assert_read_nodata_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && xcvr_rw_o) |-> (xcvr_wdata_o == '0));

    assert_go_in_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        xcvr_go_o |-> busy_o);

    assert_go_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        xcvr_go_o |=> !xcvr_go_o);

    assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_in_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);
endmodule

bind acc_call_wrapper acc_call_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .xcvr_go_o    (xcvr_go_o),
    .xcvr_rw_o    (xcvr_rw_o),
    .xcvr_addr_o  (xcvr_addr_o),
    .xcvr_wdata_o (xcvr_wdata_o)
);

// File: tb/tb_acc_call_wrapper.sv
module tb_acc_call_wrapper;
    localparam int AW = 8;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          rw_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [DW-1:0] wdata_i = '0;
    logic          xcvr_done_i = 1'b0;
    logic [DW-1:0] xcvr_rdata_i = '0;

    logic          busy_o, done_o, xcvr_rw_o, xcvr_go_o;
    logic [DW-1:0] rdata_o, xcvr_wdata_o;
    logic [AW-1:0] xcvr_addr_o;
    logic          a_busy, a_done, a_rw, a_go;
    logic [DW-1:0] a_rdata, a_wdata;
    logic [AW-1:0] a_addr;

    acc_call_wrapper #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rw_i(rw_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .busy_o(busy_o), .done_o(done_o),
        .rdata_o(rdata_o), .xcvr_addr_o(xcvr_addr_o), .xcvr_rw_o(xcvr_rw_o),
        .xcvr_wdata_o(xcvr_wdata_o), .xcvr_go_o(xcvr_go_o),
        .xcvr_done_i(xcvr_done_i), .xcvr_rdata_i(xcvr_rdata_i)
    );

    acc_call_wrapper #(.ADDR_W(AW), .DATA_W(DW), .USE_FIXED(1'b1), .FIXED_ADDR(1)) dut_auto (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rw_i(rw_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .busy_o(a_busy), .done_o(a_done),
        .rdata_o(a_rdata), .xcvr_addr_o(a_addr), .xcvr_rw_o(a_rw),
        .xcvr_wdata_o(a_wdata), .xcvr_go_o(a_go),
        .xcvr_done_i(xcvr_done_i), .xcvr_rdata_i(xcvr_rdata_i)
    );

    always #5 clk = ~clk;

    int vectors = 0;
    int errors  = 0;
    int cyc     = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    function automatic logic [DW-1:0] exp_rdata(bit rd, logic [DW-1:0] prev, logic [DW-1:0] offered);
        return rd ? offered : prev;
    endfunction

    function automatic logic [DW-1:0] exp_wdata(bit rd, logic [DW-1:0] wd);
        return rd ? '0 : wd;
    endfunction

    // Transceiver model
    int            model_lat = 0;
    logic [DW-1:0] model_val = '0;
    int            go_count = 0, go_cyc = -1, model_done_edge = -1;
    logic [AW-1:0] seen_addr, seen_auto_addr;
    logic          seen_rw, seen_auto_rw;
    logic [DW-1:0] seen_wdata;
    initial begin
        forever begin
            @(posedge clk); #1;
            if (xcvr_go_o) begin
                go_count++;
                go_cyc         = cyc;
                seen_addr      = xcvr_addr_o;
                seen_rw        = xcvr_rw_o;
                seen_wdata     = xcvr_wdata_o;
                seen_auto_addr = a_addr;
                seen_auto_rw   = a_rw;
                repeat (model_lat) @(posedge clk);
                #2;
                xcvr_done_i     = 1'b1;
                xcvr_rdata_i    = model_val;
                model_done_edge = cyc + 1;
                @(posedge clk); #2;
                xcvr_done_i  = 1'b0;
                xcvr_rdata_i = ~model_val;
            end
        end
    end

    int done_seen = -1, done_hits = 0;
    initial begin
        forever begin
            @(posedge clk); #2;
            if (done_o) begin
                done_seen = cyc;
                done_hits++;
            end
        end
    end

    logic [DW-1:0] exp_rd = '0;

    task automatic run_op(input bit rd, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                          input int lat, input bit hammer);
        int e0, go_before, hits_before, waitc;
        @(negedge clk);
        check(busy_o == 1'b0, "R6 idle before start", busy_o, 0);
        model_lat   = lat;
        model_val   = DW'($urandom);
        go_before   = go_count;
        hits_before = done_hits;
        done_seen   = -1;
        start_i = 1'b1; rw_i = rd; addr_i = a; wdata_i = wd;
        e0 = cyc + 1;
        @(negedge clk);
        if (hammer) begin
            rw_i = ~rd; addr_i = ~a; wdata_i = ~wd;
            @(negedge clk);
            check(busy_o == 1'b1, "R6 busy during transfer", busy_o, 1);
        end
        start_i = 1'b0;
        waitc = 0;
        while (done_seen < 0 && waitc < 60) begin
            @(posedge clk); #3;
            waitc++;
        end
        check(go_count == go_before + 1, "R6 one go per request", go_count - go_before, 1);
        check(go_cyc == e0 + 2, "R3 go edge", go_cyc - e0, 2);
        check(seen_addr == a, "R2 address presented", seen_addr, a);
        check(seen_rw == rd, "R1 select level", seen_rw, rd);
        check(seen_wdata == exp_wdata(rd, wd), "R1 write data", seen_wdata, exp_wdata(rd, wd));
        check(seen_auto_addr == AW'(1), "R7 fixed address", seen_auto_addr, 1);
        check(seen_auto_rw == rd, "R7 select passes", seen_auto_rw, rd);
        check(done_seen == model_done_edge + 2, "R4 done edge", done_seen - model_done_edge, 2);
        exp_rd = exp_rdata(rd, exp_rd, model_val);
        check(rdata_o == exp_rd, "R5 returned byte", rdata_o, exp_rd);
        check(a_rdata == exp_rd, "R7 returned byte", a_rdata, exp_rd);
        check(busy_o == 1'b0, "R6 busy drop", busy_o, 0);
        @(posedge clk); #3;
        check(done_hits == hits_before + 1, "R4 single done", done_hits - hits_before, 1);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        #2;
        check(busy_o == 0, "R8 busy reset", busy_o, 0);
        check(done_o == 0, "R8 done reset", done_o, 0);
        check(xcvr_go_o == 0, "R8 go reset", xcvr_go_o, 0);
        check(rdata_o == 0, "R8 rdata reset", rdata_o, 0);
        check(xcvr_addr_o == 0, "R8 addr reset", xcvr_addr_o, 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(posedge clk);

        // directed corners
        run_op(1'b1, 8'h3c, 8'h00, 0, 1'b0);   // read, zero latency
        run_op(1'b0, 8'h7e, 8'ha5, 2, 1'b0);   // write keeps last read byte (R5)
        run_op(1'b1, 8'hff, 8'h55, 5, 1'b1);   // read with start while busy (R6)
        run_op(1'b0, 8'h00, 8'hff, 1, 1'b1);   // write with start while busy
        run_op(1'b1, 8'h01, 8'h00, 3, 1'b0);

        // constrained random
        for (int i = 0; i < 40; i++) begin
            run_op(1'($urandom), AW'($urandom), DW'($urandom),
                   int'($urandom_range(0, 4)), 1'($urandom_range(0, 3) == 0));
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule